// File: doc/BRIEF.md
# Flash Erase Sequencer

This block is the erase engine of a byte-addressed NOR flash model. A caller gives it an erase opcode, a start address and the current write-enable state. From these and a set of device parameters (sector size, sector count, die count and two flags for small erase sizes), the block decides whether the erase is allowed. If it is, the block works out the length and the aligned base of the region. It then writes the erased value 0xFF over that region through a memory write port, one byte per clock.

Device capacity is sector size times sector count. Capacity, sector size and die count must each be a power of two. The start address is first reduced modulo the capacity, then aligned down to a multiple of the region length. While an erase is running, `busy` is high. A one-cycle `done` pulse marks the end of every request, and `err` is raised in that same cycle when the request was refused.

Top module: `flash_erase_seq`

## Requirements
- R1: Every accepted erase writes the value 0xFF to each byte of its region, one byte per clock, at strictly ascending contiguous addresses starting at the region base.
- R2: Opcodes 0xD8 and 0xDC erase one sector: length equals the sector size, and the base is the start address aligned down to a multiple of the sector size.
- R3: Opcode 0x20 erases 4096 bytes aligned down to 4096. It is refused when the 4 KiB capability flag is low.
- R4: Opcode 0x52 erases 32768 bytes aligned down to 32768. It is refused when the 32 KiB capability flag is low.
- R5: Opcodes 0x60 and 0xC7 erase the whole device, starting at address 0, whatever the start address.
- R6: Opcode 0xC4 erases one die. Its length is capacity divided by die count, and its base is aligned down to that length. It is refused when the die count is zero.
- R7: A request made while `wr_en` is low is refused, and no byte is written.
- R8: A refused request, including any opcode not listed above, causes no write and leaves `busy` low. It raises `done` and `err` together for exactly one cycle, in the cycle after the request.
- R9: An accepted request raises `busy` from the cycle after the request for exactly as many cycles as the region has bytes. `done` then pulses for one cycle with `err` low.
- R10: A request presented while `busy` is high is ignored and does not change the erase in progress.
- R11: Start-address bits at or above the capacity are ignored.
- R12: After reset, and after a reset that lands in the middle of an erase, `busy`, `done`, `err` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Erase request strobe, taken when `busy` is low |
| req_op | input | 8 | Erase opcode |
| req_addr | input | ADDR_W | Start address |
| wr_en | input | 1 | Current write-enable state |
| cfg_sector_bytes | input | ADDR_W+1 | Sector size in bytes (power of two) |
| cfg_sector_count | input | CNT_W | Number of sectors |
| cfg_cap_4k | input | 1 | Device supports 4 KiB erase |
| cfg_cap_32k | input | 1 | Device supports 32 KiB erase |
| cfg_die_count | input | DIE_W | Number of dies (power of two, 0 means no die erase) |
| busy | output | 1 | Erase in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Request refused, valid with `done` |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write data (erased value) |

## Verification
Some properties are checked on every clock. Writes always go to consecutive addresses. A refusal for a cleared write-enable produces `err` without `busy`. The end of `busy` always comes with a clean `done`. The first address written by a 4 KiB erase or a chip erase is aligned. Other behaviour needs the bench scenarios. These cover region lengths and bases for each opcode and each capability setting, die-boundary alignment, masking of high address bits, a request ignored during an erase, and reset in the middle of an erase. The bench checks these by counting writes and busy cycles against values it computes itself.

// File: rtl/flash_erase_pkg.sv
// Shared definitions for the erase sequencer: opcode values and the
// region kind that the decoder hands to the walker.
// Assumes 8-bit opcodes.
package flash_erase_pkg;

    localparam logic [7:0] OP_ERASE_4K    = 8'h20;
    localparam logic [7:0] OP_ERASE_32K   = 8'h52;
    localparam logic [7:0] OP_ERASE_SECT  = 8'hD8;
    localparam logic [7:0] OP_ERASE_SECT4 = 8'hDC;
    localparam logic [7:0] OP_ERASE_CHIP  = 8'h60;
    localparam logic [7:0] OP_ERASE_CHIP2 = 8'hC7;
    localparam logic [7:0] OP_ERASE_DIE   = 8'hC4;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    typedef enum logic [2:0] {
        KIND_NONE,
        KIND_4K,
        KIND_32K,
        KIND_SECTOR,
        KIND_CHIP,
        KIND_DIE
    } erase_kind_e;

    // Map an opcode onto the kind of region it erases.
    function automatic erase_kind_e kind_of(input logic [7:0] op);
        case (op)
            OP_ERASE_4K:                    return KIND_4K;
            OP_ERASE_32K:                   return KIND_32K;
            OP_ERASE_SECT, OP_ERASE_SECT4:  return KIND_SECTOR;
            OP_ERASE_CHIP, OP_ERASE_CHIP2:  return KIND_CHIP;
            OP_ERASE_DIE:                   return KIND_DIE;
            default:                        return KIND_NONE;
        endcase
    endfunction

endpackage

// File: rtl/erase_region_calc.sv
// Combinational decoder: classifies the opcode, checks that the erase is
// allowed, and computes the length and aligned base of the region.
// Assumes capacity, sector size and die count are powers of two, and that
// every region length is at most the capacity.
module erase_region_calc
    import flash_erase_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16,
    parameter int DIE_W  = 4,
    localparam int LEN_W = ADDR_W + 1
) (
    input  logic [7:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [LEN_W-1:0]  sector_bytes,
    input  logic [CNT_W-1:0]  sector_count,
    input  logic              cap_4k,
    input  logic              cap_32k,
    input  logic [DIE_W-1:0]  die_count,
    output logic              reject,
    output logic [ADDR_W-1:0] base,
    output logic [LEN_W-1:0]  len
);

    localparam logic [LEN_W-1:0] LEN_4K  = LEN_W'(4096);
    localparam logic [LEN_W-1:0] LEN_32K = LEN_W'(32768);

    erase_kind_e         kind;
    logic [LEN_W-1:0]    capacity;
    logic [LEN_W-1:0]    die_len;
    logic [ADDR_W-1:0]   addr_in_dev;
    logic [$clog2(DIE_W+1)-1:0] die_shift;

    // Index of the highest set bit of the die count (its log2).
    always_comb begin
        die_shift = '0;
        for (int i = 0; i < DIE_W; i++) begin
            if (die_count[i]) die_shift = ($clog2(DIE_W+1))'(i);
        end
    end

    // Capacity, die size and the start address folded into the device.
    always_comb begin
        kind        = kind_of(op);
        capacity    = sector_bytes * LEN_W'(sector_count);
        die_len     = capacity >> die_shift;
        addr_in_dev = addr & ADDR_W'(capacity - 1'b1);
    end

    // Pick the region length and decide whether the request is refused.
    always_comb begin
        len    = '0;
        reject = !wr_en;
        unique case (kind)
            KIND_4K:     begin len = LEN_4K;       if (!cap_4k)  reject = 1'b1; end
            KIND_32K:    begin len = LEN_32K;      if (!cap_32k) reject = 1'b1; end
            KIND_SECTOR: len = sector_bytes;
            KIND_CHIP:   len = capacity;
            KIND_DIE:    begin len = die_len; if (die_count == '0) reject = 1'b1; end
            default:     reject = 1'b1;
        endcase
    end

    // Align the folded address down to a multiple of the region length.
    always_comb begin
        base = addr_in_dev & ~ADDR_W'(len - 1'b1);
    end

endmodule

// File: rtl/erase_walker.sv
// Sequential walker: on an accepted request, writes the erased value to
// one byte per cycle from the base for len bytes; on a refused one,
// pulses done and err. Requests are taken only while idle.
module erase_walker
    import flash_erase_pkg::*;
#(
    parameter int ADDR_W = 24,
    localparam int LEN_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              reject,
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  len,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);

    logic [ADDR_W-1:0] ptr;
    logic [LEN_W-1:0]  left;

    // Accept or refuse requests, step the pointer, and end the erase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            err  <= 1'b0;
            ptr  <= '0;
            left <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            if (busy) begin
                ptr  <= ptr + 1'b1;
                left <= left - 1'b1;
                if (left == LEN_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end else if (start) begin
                if (reject || len == '0) begin
                    done <= 1'b1;
                    err  <= 1'b1;
                end else begin
                    busy <= 1'b1;
                    ptr  <= base;
                    left <= len;
                end
            end
        end
    end

    // Drive the memory port while the erase runs.
    always_comb begin
        mem_we    = busy;
        mem_addr  = ptr;
        mem_wdata = ERASED_BYTE;
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> mem_addr == $past(mem_addr) + 1'b1); // R1
    AST_END_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done && !err); // R9
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done && !busy && !mem_we); // R8

endmodule

// File: rtl/flash_erase_seq.sv
// Top of the erase sequencer: ties the region decoder to the byte walker.
// Assumes the caller holds the device parameters stable while busy.
module flash_erase_seq
    import flash_erase_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16,
    parameter int DIE_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [7:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              wr_en,
    input  logic [ADDR_W:0]   cfg_sector_bytes,
    input  logic [CNT_W-1:0]  cfg_sector_count,
    input  logic              cfg_cap_4k,
    input  logic              cfg_cap_32k,
    input  logic [DIE_W-1:0]  cfg_die_count,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);

    localparam int LEN_W = ADDR_W + 1;

    logic              rq_reject;
    logic [ADDR_W-1:0] rq_base;
    logic [LEN_W-1:0]  rq_len;

    erase_region_calc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DIE_W(DIE_W)) u_calc (
        .op           (req_op),
        .addr         (req_addr),
        .wr_en        (wr_en),
        .sector_bytes (cfg_sector_bytes),
        .sector_count (cfg_sector_count),
        .cap_4k       (cfg_cap_4k),
        .cap_32k      (cfg_cap_32k),
        .die_count    (cfg_die_count),
        .reject       (rq_reject),
        .base         (rq_base),
        .len          (rq_len)
    );

    erase_walker #(.ADDR_W(ADDR_W)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (req_valid),
        .reject    (rq_reject),
        .base      (rq_base),
        .len       (rq_len),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    AST_WE_LOW_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !busy && !wr_en |=> err && !busy); // R7
    AST_4K_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !busy && wr_en && cfg_cap_4k && req_op == OP_ERASE_4K
        |=> busy && mem_addr[11:0] == 12'h000); // R3
    AST_CHIP_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !busy && wr_en && req_op == OP_ERASE_CHIP
        |=> busy && mem_addr == '0); // R5

endmodule

// File: tb/sim_flash_erase_seq.sv
module sim_flash_erase_seq;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;
    localparam int NV = 14;
    localparam int WATCHDOG = 190000;

    typedef struct packed {
        logic [7:0]  op;
        logic [23:0] addr;
        logic        we;
        logic        c4;
        logic        c32;
        logic [3:0]  die;
        logic        xerr;
        logic [23:0] xbase;
        logic [24:0] xlen;
    } vec_t;

    // Device: 512-byte sectors x 64 = 32 KiB.
    localparam vec_t VEC [NV] = '{
        '{8'hD8, 24'h001234, 1'b1, 1'b1, 1'b1, 4'd4, 1'b0, 24'h001200, 25'd512},
        '{8'hDC, 24'h007FFF, 1'b1, 1'b1, 1'b1, 4'd4, 1'b0, 24'h007E00, 25'd512},
        '{8'h20, 24'h002345, 1'b1, 1'b1, 1'b0, 4'd4, 1'b0, 24'h002000, 25'd4096},
        '{8'h20, 24'h002345, 1'b1, 1'b0, 1'b1, 4'd4, 1'b1, 24'h000000, 25'd0},
        '{8'h52, 24'h004000, 1'b1, 1'b0, 1'b1, 4'd4, 1'b0, 24'h000000, 25'd32768},
        '{8'h52, 24'h004000, 1'b1, 1'b1, 1'b0, 4'd4, 1'b1, 24'h000000, 25'd0},
        '{8'h60, 24'h001111, 1'b1, 1'b1, 1'b1, 4'd4, 1'b0, 24'h000000, 25'd32768},
        '{8'hC7, 24'h006789, 1'b1, 1'b1, 1'b1, 4'd4, 1'b0, 24'h000000, 25'd32768},
        '{8'hC4, 24'h005123, 1'b1, 1'b1, 1'b1, 4'd4, 1'b0, 24'h004000, 25'd8192},
        '{8'hC4, 24'h005123, 1'b1, 1'b1, 1'b1, 4'd0, 1'b1, 24'h000000, 25'd0},
        '{8'hD8, 24'h001234, 1'b0, 1'b1, 1'b1, 4'd4, 1'b1, 24'h000000, 25'd0},
        '{8'h03, 24'h001234, 1'b1, 1'b1, 1'b1, 4'd4, 1'b1, 24'h000000, 25'd0},
        '{8'hD8, 24'hFF1234, 1'b1, 1'b1, 1'b1, 4'd4, 1'b0, 24'h001200, 25'd512},
        '{8'hC4, 24'h003333, 1'b1, 1'b1, 1'b1, 4'd8, 1'b0, 24'h003000, 25'd4096}
    };

    string vtag [NV] = '{"R2", "R2", "R3", "R3", "R4", "R4", "R5", "R5",
                         "R6", "R6", "R7", "R8", "R11", "R6"};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [7:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic          wr_en = 1'b0;
    logic [AW:0]   cfg_sector_bytes = 25'd512;
    logic [15:0]   cfg_sector_count = 16'd64;
    logic          cfg_cap_4k = 1'b0;
    logic          cfg_cap_32k = 1'b0;
    logic [3:0]    cfg_die_count = 4'd0;
    logic          busy, done, err, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    int wcount   = 0;
    int bad      = 0;
    int dcount   = 0;
    logic [AW-1:0] first_addr, prev_addr;

    flash_erase_seq u0 (
        .clk, .rst_n, .req_valid, .req_op, .req_addr, .wr_en,
        .cfg_sector_bytes, .cfg_sector_count, .cfg_cap_4k, .cfg_cap_32k,
        .cfg_die_count, .busy, .done, .err, .mem_we, .mem_addr, .mem_wdata
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles, expected < %0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    // Write monitor: records first address, contiguity and data (R1).
    always @(negedge clk) begin
        if (done) dcount++;
        if (mem_we) begin
            if (wcount == 0) first_addr = mem_addr;
            else if (mem_addr != prev_addr + 1'b1) bad++;
            if (mem_wdata != 8'hFF) bad++;
            prev_addr = mem_addr;
            wcount++;
        end
    end

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input string tag);
        int bcyc;
        @(negedge clk);
        req_op = v.op; req_addr = v.addr; wr_en = v.we;
        cfg_cap_4k = v.c4; cfg_cap_32k = v.c32; cfg_die_count = v.die;
        wcount = 0; bad = 0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        bcyc = 0;
        for (int i = 0; i < 40000; i++) begin
            if (done) break;
            if (busy) bcyc++;
            @(negedge clk);
        end
        check(err == v.xerr, {tag, " err"}, err, v.xerr);
        check(wcount == int'(v.xlen), {tag, " bytes written"}, wcount, v.xlen);
        check(bcyc == int'(v.xlen), "R9 busy length", bcyc, v.xlen);
        if (v.xlen != 0) begin
            check(first_addr == v.xbase, {tag, " base"}, first_addr, v.xbase);
            check(bad == 0, "R1 contiguous 0xFF", bad, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !err && !mem_we, "R12 reset state",
              {busy, done, err, mem_we}, 0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) run_vec(VEC[k], vtag[k]);

        // R10: request during an erase is ignored.
        @(negedge clk);
        req_op = 8'hD8; req_addr = '0; wr_en = 1'b1;
        wcount = 0; bad = 0; dcount = 0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        req_op = 8'h60; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            if (done) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
        check(wcount == 512, "R10 bytes written", wcount, 512);
        check(dcount == 1, "R10 done pulses", dcount, 1);
        check(!busy, "R10 idle after", busy, 0);

        // R12: reset in the middle of an erase.
        req_op = 8'h60; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(!busy && !done && !err && !mem_we, "R12 mid-erase reset",
              {busy, done, err, mem_we}, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule